// File: doc/BRIEF.md
# Ethernet Address Lookup Table Engine

This block holds the forwarding table of a small Ethernet switch. Each table entry is a packed record. It carries an entry type, a 48-bit MAC address and, depending on the address, either a unicast record (egress port number, secure flag, blocked flag, ageing class) or a multicast record (egress port mask, forwarding class). Software never addresses the table directly. It stages an entry in three data words and moves it to or from the table by writing an index to a table-command register.

A lookup port takes a 48-bit destination MAC. It walks the table from index 0 upward, one entry per cycle, and returns an egress port mask with a one-cycle valid pulse. That mask comes from the first matching address entry, or it is the full port set on a miss. Before it leaves the block, the result is reduced to the ports whose 2-bit state is "forwarding". Global controls enable the engine, bypass the table, and wipe every entry back to free. The wipe takes one entry per cycle.

With the default of 3 ports, an entry is 69 bits wide: the 68-bit base record plus the top bit of the 3-bit multicast mask that starts at bit 66.

Top module: `alt_engine`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, `lk_valid` and `lk_busy` are 0, and every table entry is zero, which means it is of type free.
- R2: Entry bits are staged in three words: offset 2 holds bits ENTRY_W-1:64 in its low bits, offset 3 holds bits 63:32, and offset 4 holds bits 31:0. Writing offset 1 with bit 31 set commits the staged words to the entry named by the low index bits. Writing offset 1 with bit 31 clear loads that entry into the staged words.
- R3: Offset 1 reads back the last index written, with bit 31 reading 0.
- R4: Writing offset 0 with bit 30 set starts a wipe. The wipe forces bits 61:60 (entry type) of entry k to 0 in the k-th following cycle and leaves every other entry bit unchanged. Bit 30 of offset 0 reads 1 for exactly NUM_ENTRIES cycles.
- R5: Offset 0 bit 31 enables the engine. A lookup accepted while the engine is disabled returns mask 0 one cycle after the request.
- R6: Offset 0 bit 4 selects bypass. An accepted lookup then returns the forwarding port set one cycle after the request, without using the table.
- R7: Entries are scanned in ascending index order and the lowest matching index wins. A hit at index k gives `lk_valid` k+2 cycles after the request cycle. A miss gives it NUM_ENTRIES+1 cycles after.
- R8: On a hit whose address has bit 40 clear (unicast), the result is the one-hot mask of the port number in bits 67:66. If bit 65 (blocked) is set, the result is 0.
- R9: On a hit whose address has bit 40 set (multicast), the result is the mask held in bits 66 upward, NUM_PORTS bits wide.
- R10: A miss returns all ports.
- R11: Port p's state is at offset 8+p, in bits 1:0 (0 disabled, 1 blocking, 2 learning, 3 forwarding). Every result is ANDed with the set of ports in state 3.
- R12: A lookup request raised while `lk_busy` is 1 (scan in progress or wipe running) is ignored. It produces no result.
- R13: Only entries of type 1 (address) or 3 (VLAN plus address) in bits 61:60 can match. Types 0 and 2 never match, even when bits 47:0 are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| lk_req | input | 1 | Lookup request, accepted when lk_busy is 0 |
| lk_mac | input | 48 | Destination MAC to look up |
| lk_busy | output | 1 | Scan or wipe in progress |
| lk_valid | output | 1 | One-cycle result strobe |
| lk_mask | output | NUM_PORTS | Egress port mask, valid with lk_valid |

## Verification
The hardest situations to reach from the ports are the overlaps in time: a second lookup request arriving in the middle of a scan, and the staged data being read back after a wipe has already passed over an entry. The stimulus handles the first by raising a request that would hit, three cycles into a scan that will miss, and then counting result strobes over the whole window. It handles the second by polling the wipe flag cycle by cycle until it drops, then loading an entry through the indirect path to confirm that only the type bits were cleared. A behavioural model, updated on every edge, also compares the read data, busy and result outputs on every cycle, so unintended overlaps are caught as well.

// File: rtl/alt_pkg.sv
// Package: shared field positions, register offsets and encodings of the
// address lookup table engine. Assumes a 4-bit register word offset.
package alt_pkg;
    // entry field positions
    localparam int F_MCAST   = 40;
    localparam int F_TYPE_LO = 60;
    localparam int F_SECURE  = 64;
    localparam int F_BLOCKED = 65;
    localparam int F_PORT_LO = 66;
    localparam int F_MASK_LO = 66;

    // register word offsets
    localparam logic [3:0] OFS_CTRL  = 4'd0;
    localparam logic [3:0] OFS_TCMD  = 4'd1;
    localparam logic [3:0] OFS_WHI   = 4'd2;
    localparam logic [3:0] OFS_WMID  = 4'd3;
    localparam logic [3:0] OFS_WLO   = 4'd4;
    localparam logic [3:0] OFS_PORT  = 4'd8;

    // control bits
    localparam int C_EN   = 31;
    localparam int C_CLR  = 30;
    localparam int C_BYP  = 4;
    localparam int C_VLAN = 2;
    localparam int T_COMMIT = 31;

    typedef enum logic [1:0] {
        PS_OFF   = 2'd0,
        PS_BLOCK = 2'd1,
        PS_LEARN = 2'd2,
        PS_FWD   = 2'd3
    } port_state_e;
endpackage

// File: rtl/alt_regs.sv
// Register file: global control, table command/index, the three staging
// words and per-port 2-bit states. Assumes NUM_PORTS <= 8 so port registers
// fit between offsets 8 and 15. Reads are combinational on reg_addr.
module alt_regs
    import alt_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int IDX_W     = 4,
    parameter int ENTRY_W   = 69
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [3:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 clr_busy,
    input  logic [ENTRY_W-1:0]   rd_entry,
    output logic [IDX_W-1:0]     tbl_idx,
    output logic                 tbl_commit,
    output logic [ENTRY_W-1:0]   stage,
    output logic                 clr_start,
    output logic                 eng_en,
    output logic                 eng_byp,
    output logic [NUM_PORTS-1:0] fwd_mask
);
    localparam int HI_W = ENTRY_W - 64;

    logic             vlan_q;
    logic [IDX_W-1:0] idx_q;
    logic [1:0]       ps_q [NUM_PORTS];
    logic             tcmd_wr;
    logic             tbl_load;

    assign tcmd_wr    = reg_we && (reg_addr == OFS_TCMD);
    assign tbl_commit = tcmd_wr && reg_wdata[T_COMMIT];
    assign tbl_load   = tcmd_wr && !reg_wdata[T_COMMIT];
    assign tbl_idx    = reg_wdata[IDX_W-1:0];
    assign clr_start  = reg_we && (reg_addr == OFS_CTRL) && reg_wdata[C_CLR] && !clr_busy;

    // Global control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_en  <= 1'b0;
            eng_byp <= 1'b0;
            vlan_q  <= 1'b0;
        end else if (reg_we && reg_addr == OFS_CTRL) begin
            eng_en  <= reg_wdata[C_EN];
            eng_byp <= reg_wdata[C_BYP];
            vlan_q  <= reg_wdata[C_VLAN];
        end
    end

    // Index last written to the table command register.
    always_ff @(posedge clk) begin
        if (!rst_n)       idx_q <= '0;
        else if (tcmd_wr) idx_q <= reg_wdata[IDX_W-1:0];
    end

    // Staging words: loaded from the table or written word by word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
        end else if (tbl_load) begin
            stage <= rd_entry;
        end else if (reg_we) begin
            if (reg_addr == OFS_WHI)  stage[ENTRY_W-1:64] <= reg_wdata[HI_W-1:0];
            if (reg_addr == OFS_WMID) stage[63:32]        <= reg_wdata;
            if (reg_addr == OFS_WLO)  stage[31:0]         <= reg_wdata;
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        // Per-port forwarding state register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ps_q[p] <= PS_OFF;
            else if (reg_we && reg_addr == OFS_PORT + 4'(p))
                ps_q[p] <= reg_wdata[1:0];
        end
        assign fwd_mask[p] = (ps_q[p] == PS_FWD);
    end

    // Read-back multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[C_EN]   = eng_en;
                reg_rdata[C_CLR]  = clr_busy;
                reg_rdata[C_BYP]  = eng_byp;
                reg_rdata[C_VLAN] = vlan_q;
            end
            OFS_TCMD: reg_rdata[IDX_W-1:0] = idx_q;
            OFS_WHI:  reg_rdata[HI_W-1:0]  = stage[ENTRY_W-1:64];
            OFS_WMID: reg_rdata            = stage[63:32];
            OFS_WLO:  reg_rdata            = stage[31:0];
            default: begin
                for (int p = 0; p < NUM_PORTS; p++)
                    if (reg_addr == OFS_PORT + 4'(p)) reg_rdata[1:0] = ps_q[p];
            end
        endcase
    end
endmodule

// File: rtl/alt_table.sv
// Entry storage with a sequential wipe. The wipe frees one entry per cycle
// by zeroing its type bits. A commit in the same cycle overrides the wipe for
// its entry. Indices at or above NUM_ENTRIES read 0 and are not written.
module alt_table
    import alt_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int IDX_W       = 4,
    parameter int ENTRY_W     = 69
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_start,
    output logic               clr_busy,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_entry,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [ENTRY_W-1:0] rd_entry,
    input  logic [IDX_W-1:0]   scan_idx,
    output logic [ENTRY_W-1:0] scan_entry
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENTRIES - 1);

    logic [ENTRY_W-1:0] mem [NUM_ENTRIES];
    logic [IDX_W-1:0]   clr_idx;
    logic               wr_ok;
    logic               rd_ok;

    if (2**IDX_W == NUM_ENTRIES) begin : g_full
        assign wr_ok = 1'b1;
        assign rd_ok = 1'b1;
    end else begin : g_part
        assign wr_ok = (wr_idx <= LAST);
        assign rd_ok = (rd_idx <= LAST);
    end

    assign rd_entry   = rd_ok ? mem[rd_idx] : '0;
    assign scan_entry = mem[scan_idx];

    // Storage update: reset, wipe step, then software commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) mem[i] <= '0;
            clr_busy <= 1'b0;
            clr_idx  <= '0;
        end else begin
            if (clr_busy) begin
                mem[clr_idx][F_TYPE_LO +: 2] <= 2'b00;
                if (clr_idx == LAST) clr_busy <= 1'b0;
                else                 clr_idx  <= clr_idx + 1'b1;
            end else if (clr_start) begin
                clr_busy <= 1'b1;
                clr_idx  <= '0;
            end
            if (wr_en && wr_ok) mem[wr_idx] <= wr_entry;
        end
    end
endmodule

// File: rtl/alt_search.sv
// Lookup sequencer: accepts a request when idle, scans entries in ascending
// order one per cycle, and emits a one-cycle result gated by forwarding ports.
// Assumes NUM_PORTS <= 4 so a unicast port number fits bits 67:66.
module alt_search
    import alt_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_PORTS   = 3,
    parameter int IDX_W       = 4,
    parameter int ENTRY_W     = 69
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_req,
    input  logic [47:0]          lk_mac,
    input  logic                 eng_en,
    input  logic                 eng_byp,
    input  logic                 clr_busy,
    input  logic [NUM_PORTS-1:0] fwd_mask,
    output logic [IDX_W-1:0]     scan_idx,
    input  logic [ENTRY_W-1:0]   scan_entry,
    output logic                 scan_on,
    output logic                 lk_busy,
    output logic                 lk_valid,
    output logic [NUM_PORTS-1:0] lk_mask
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENTRIES - 1);

    logic [47:0]          key_q;
    logic                 hit;
    logic                 last;
    logic                 accept;
    logic [NUM_PORTS-1:0] uc_mask;
    logic [NUM_PORTS-1:0] hit_mask;
    logic                 unused_fields;

    assign unused_fields = ^{scan_entry[F_SECURE], scan_entry[63:61], scan_entry[59:48]};

    assign lk_busy = scan_on || clr_busy;
    assign accept  = lk_req && !lk_busy;
    assign hit     = scan_entry[F_TYPE_LO] && (scan_entry[47:0] == key_q);
    assign last    = (scan_idx == LAST);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_uc
        assign uc_mask[p] = (scan_entry[F_PORT_LO +: 2] == 2'(p));
    end

    // Result mask of the entry under scan, by record kind.
    always_comb begin
        if (scan_entry[F_MCAST])        hit_mask = scan_entry[F_MASK_LO +: NUM_PORTS];
        else if (scan_entry[F_BLOCKED]) hit_mask = '0;
        else                            hit_mask = uc_mask;
    end

    // Request acceptance, scan stepping and result registration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_on  <= 1'b0;
            scan_idx <= '0;
            key_q    <= '0;
            lk_valid <= 1'b0;
            lk_mask  <= '0;
        end else begin
            lk_valid <= 1'b0;
            if (scan_on) begin
                if (hit) begin
                    lk_valid <= 1'b1;
                    lk_mask  <= hit_mask & fwd_mask;
                    scan_on  <= 1'b0;
                end else if (last) begin
                    lk_valid <= 1'b1;
                    lk_mask  <= fwd_mask;
                    scan_on  <= 1'b0;
                end else begin
                    scan_idx <= scan_idx + 1'b1;
                end
            end else if (accept) begin
                if (!eng_en) begin
                    lk_valid <= 1'b1;
                    lk_mask  <= '0;
                end else if (eng_byp) begin
                    lk_valid <= 1'b1;
                    lk_mask  <= fwd_mask;
                end else begin
                    scan_on  <= 1'b1;
                    scan_idx <= '0;
                    key_q    <= lk_mac;
                end
            end
        end
    end
endmodule

// File: rtl/alt_engine.sv
// Top of the address lookup table engine: register file, entry storage with
// wipe, and lookup sequencer. Assumes NUM_PORTS between 1 and 4.
module alt_engine
    import alt_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_PORTS   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [3:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 lk_req,
    input  logic [47:0]          lk_mac,
    output logic                 lk_busy,
    output logic                 lk_valid,
    output logic [NUM_PORTS-1:0] lk_mask
);
    localparam int IDX_W   = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam int ENTRY_W = (F_MASK_LO + NUM_PORTS > 68) ? F_MASK_LO + NUM_PORTS : 68;

    logic                 clr_busy;
    logic                 clr_start;
    logic                 scan_on;
    logic                 tbl_commit;
    logic                 eng_en;
    logic                 eng_byp;
    logic [IDX_W-1:0]     tbl_idx;
    logic [IDX_W-1:0]     scan_idx;
    logic [ENTRY_W-1:0]   stage;
    logic [ENTRY_W-1:0]   rd_entry;
    logic [ENTRY_W-1:0]   scan_entry;
    logic [NUM_PORTS-1:0] fwd_mask;

    alt_regs #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clr_busy(clr_busy),
        .rd_entry(rd_entry), .tbl_idx(tbl_idx), .tbl_commit(tbl_commit),
        .stage(stage), .clr_start(clr_start), .eng_en(eng_en),
        .eng_byp(eng_byp), .fwd_mask(fwd_mask)
    );

    alt_table #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_table (
        .clk(clk), .rst_n(rst_n), .clr_start(clr_start), .clr_busy(clr_busy),
        .wr_en(tbl_commit), .wr_idx(tbl_idx), .wr_entry(stage),
        .rd_idx(tbl_idx), .rd_entry(rd_entry),
        .scan_idx(scan_idx), .scan_entry(scan_entry)
    );

    alt_search #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W),
                 .ENTRY_W(ENTRY_W)) u_search (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_mac(lk_mac),
        .eng_en(eng_en), .eng_byp(eng_byp), .clr_busy(clr_busy),
        .fwd_mask(fwd_mask), .scan_idx(scan_idx), .scan_entry(scan_entry),
        .scan_on(scan_on), .lk_busy(lk_busy), .lk_valid(lk_valid),
        .lk_mask(lk_mask)
    );
endmodule

// File: rtl/alt_engine_chk.sv
// Checker for alt_engine: wipe length, scan length bound, forwarding gating
// of results, and no scan start while a wipe runs. Bound to the top below.
module alt_engine_chk #(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_PORTS   = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 clr_busy,
    input logic                 scan_on,
    input logic                 lk_valid,
    input logic [NUM_PORTS-1:0] lk_mask,
    input logic [NUM_PORTS-1:0] fwd_mask
);
    localparam int CW = $clog2(NUM_ENTRIES + 1) + 1;

    logic [CW-1:0] clr_cnt;
    logic [CW-1:0] scan_cnt;

    // Count consecutive cycles of wipe and of scanning.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_cnt  <= '0;
            scan_cnt <= '0;
        end else begin
            clr_cnt  <= clr_busy ? clr_cnt + 1'b1 : '0;
            scan_cnt <= scan_on ? scan_cnt + 1'b1 : '0;
        end
    end

    p_clear_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clr_busy) |-> (clr_cnt == CW'(NUM_ENTRIES)));

    p_scan_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        scan_on |-> (scan_cnt < CW'(NUM_ENTRIES)));

    p_fwd_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> ((lk_mask & ~$past(fwd_mask)) == '0));

    p_no_scan_in_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        clr_busy |=> !$rose(scan_on));
endmodule

bind alt_engine alt_engine_chk #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_PORTS(NUM_PORTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr_busy(clr_busy), .scan_on(scan_on),
    .lk_valid(lk_valid), .lk_mask(lk_mask), .fwd_mask(fwd_mask)
);

// File: tb/alt_engine_tb.sv
// Bench: behavioural per-cycle model plus directed scenarios for alt_engine.
module alt_engine_tb;
    localparam int N = 16;
    localparam int P = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_req = 1'b0;
    logic [47:0] lk_mac = '0;
    logic        lk_busy;
    logic        lk_valid;
    logic [P-1:0] lk_mask;

    always #5 clk = ~clk;

    alt_engine #(.NUM_ENTRIES(N), .NUM_PORTS(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_req(lk_req),
        .lk_mac(lk_mac), .lk_busy(lk_busy), .lk_valid(lk_valid), .lk_mask(lk_mask)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural model ----------------
    logic [68:0] m_tab [N];
    logic [68:0] m_stage;
    logic [3:0]  m_tidx;
    logic [1:0]  m_ps [P];
    logic [47:0] m_key;
    logic [P-1:0] m_mask;
    bit m_en, m_byp, m_vlan, m_clr, m_scan, m_valid;
    int m_cidx, m_sidx;

    function automatic logic [P-1:0] m_fwd();
        logic [P-1:0] f;
        for (int p = 0; p < P; p++) f[p] = (m_ps[p] == 2'd3);
        return f;
    endfunction

    function automatic logic [P-1:0] m_entry_mask(input logic [68:0] e);
        int pn;
        if (e[40]) return e[68:66];
        if (e[65]) return '0;
        pn = int'(e[67:66]);
        return (pn < P) ? P'(1 << pn) : '0;
    endfunction

    // Model update on each rising edge from pre-edge state and inputs.
    always @(posedge clk) begin : model
        logic [P-1:0] fw;
        logic [68:0] e, ld;
        bit pre_busy, pre_clr;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_tab[i] = '0;
            for (int p = 0; p < P; p++) m_ps[p] = '0;
            m_stage = '0; m_tidx = '0; m_key = '0; m_mask = '0;
            m_en = 0; m_byp = 0; m_vlan = 0; m_clr = 0; m_scan = 0; m_valid = 0;
            m_cidx = 0; m_sidx = 0;
        end else begin
            fw = m_fwd();
            pre_clr = m_clr;
            pre_busy = m_scan || m_clr;
            m_valid = 0;
            if (m_scan) begin
                e = m_tab[m_sidx];
                if ((e[61:60] == 2'd1 || e[61:60] == 2'd3) && e[47:0] == m_key) begin
                    m_valid = 1; m_mask = m_entry_mask(e) & fw; m_scan = 0;
                end else if (m_sidx == N - 1) begin
                    m_valid = 1; m_mask = fw; m_scan = 0;
                end else m_sidx++;
            end else if (lk_req && !pre_busy) begin
                if (!m_en) begin m_valid = 1; m_mask = '0; end
                else if (m_byp) begin m_valid = 1; m_mask = fw; end
                else begin m_scan = 1; m_sidx = 0; m_key = lk_mac; end
            end
            ld = m_tab[reg_wdata[3:0]];
            if (m_clr) begin
                m_tab[m_cidx][61:60] = 2'b00;
                if (m_cidx == N - 1) m_clr = 0; else m_cidx++;
            end
            if (reg_we) begin
                case (reg_addr)
                    4'd0: begin
                        m_en = reg_wdata[31]; m_byp = reg_wdata[4]; m_vlan = reg_wdata[2];
                        if (reg_wdata[30] && !pre_clr) begin m_clr = 1; m_cidx = 0; end
                    end
                    4'd1: begin
                        m_tidx = reg_wdata[3:0];
                        if (reg_wdata[31]) m_tab[reg_wdata[3:0]] = m_stage;
                        else m_stage = ld;
                    end
                    4'd2: m_stage[68:64] = reg_wdata[4:0];
                    4'd3: m_stage[63:32] = reg_wdata;
                    4'd4: m_stage[31:0] = reg_wdata;
                    default: if (reg_addr >= 4'd8 && reg_addr < 4'd8 + 4'(P))
                        m_ps[reg_addr - 4'd8] = reg_wdata[1:0];
                endcase
            end
        end
    end

    function automatic logic [31:0] m_rdata(input logic [3:0] a);
        logic [31:0] r = '0;
        case (a)
            4'd0: begin r[31] = m_en; r[30] = m_clr; r[4] = m_byp; r[2] = m_vlan; end
            4'd1: r[3:0] = m_tidx;
            4'd2: r[4:0] = m_stage[68:64];
            4'd3: r = m_stage[63:32];
            4'd4: r = m_stage[31:0];
            default: if (a >= 4'd8 && a < 4'd8 + 4'(P)) r[1:0] = m_ps[a - 4'd8];
        endcase
        return r;
    endfunction

    // Per-cycle comparison, one time unit before each rising edge.
    always @(negedge clk) begin
        #4;
        if (rst_n && !finished) begin
            chk(reg_rdata == m_rdata(reg_addr), "R2 R3 model rdata", reg_rdata, m_rdata(reg_addr));
            chk(lk_valid == m_valid, "R7 model valid", 32'(lk_valid), 32'(m_valid));
            chk(lk_busy == (m_scan || m_clr), "R12 model busy", 32'(lk_busy), 32'(m_scan || m_clr));
            if (lk_valid && m_valid)
                chk(lk_mask == m_mask, "R11 model mask", 32'(lk_mask), 32'(m_mask));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic put(input int idx, input logic [68:0] e);
        wr(4'd2, {27'b0, e[68:64]});
        wr(4'd3, e[63:32]);
        wr(4'd4, e[31:0]);
        wr(4'd1, 32'h8000_0000 | 32'(idx));
    endtask

    function automatic logic [68:0] uc(input logic [47:0] mac, input int pn, input bit blk);
        logic [68:0] e = '0;
        e[61:60] = 2'd1; e[47:0] = mac; e[67:66] = 2'(pn); e[65] = blk; e[64] = 1'b1;
        return e;
    endfunction

    function automatic logic [68:0] mc(input logic [47:0] mac, input logic [2:0] m);
        logic [68:0] e = '0;
        e[61:60] = 2'd1; e[63:62] = 2'd3; e[47:0] = mac; e[68:66] = m;
        return e;
    endfunction

    task automatic look(input logic [47:0] mac, input logic [P-1:0] exp_mask,
                        input int exp_lat, input string tag);
        int n;
        lk_mac = mac; lk_req = 1'b1;
        @(negedge clk);
        lk_req = 1'b0;
        n = 1;
        while (!lk_valid && n < 40) begin @(negedge clk); n++; end
        chk(lk_mask == exp_mask, {tag, " mask"}, 32'(lk_mask), 32'(exp_mask));
        chk(n == exp_lat, {tag, " latency"}, 32'(n), 32'(exp_lat));
        @(negedge clk);
    endtask

    localparam logic [47:0] MAC_A = 48'h02_11_22_33_44_55;
    localparam logic [47:0] MAC_B = 48'h02_aa_bb_cc_dd_ee;
    localparam logic [47:0] MAC_M = 48'h01_00_5e_00_00_07;
    localparam logic [47:0] MAC_C = 48'h02_0c_0c_0c_0c_0c;
    localparam logic [47:0] MAC_X = 48'h02_99_99_99_99_99;

    initial begin : main
        logic [31:0] d;
        logic [68:0] ea;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 11; a++) begin
            rd(4'(a), d);
            chk(d == 0, "R1 reset register", d, 0);
        end
        chk(!lk_valid && !lk_busy, "R1 reset lookup outputs", {lk_valid, lk_busy}, 0);
        wr(4'd1, 32'd9);
        rd(4'd3, d);
        chk(d == 0, "R1 reset table entry", d, 0);

        // R5: disabled engine
        look(MAC_A, 3'b000, 1, "R5 disabled");

        wr(4'd0, 32'h8000_0000);
        wr(4'd8, 32'd3); wr(4'd9, 32'd3); wr(4'd10, 32'd3);

        // R10: miss on empty table
        look(MAC_A, 3'b111, N + 1, "R10 miss empty");

        // R2/R3: indirect write and read back
        ea = uc(MAC_A, 2, 1'b0);
        put(3, ea);
        rd(4'd1, d);
        chk(d == 32'd3, "R3 index readback", d, 3);
        wr(4'd2, 32'h0); wr(4'd3, 32'h0); wr(4'd4, 32'h0);
        wr(4'd1, 32'd3);
        rd(4'd2, d); chk(d == {27'b0, ea[68:64]}, "R2 high word", d, {27'b0, ea[68:64]});
        rd(4'd3, d); chk(d == ea[63:32], "R2 middle word", d, ea[63:32]);
        rd(4'd4, d); chk(d == ea[31:0], "R2 low word", d, ea[31:0]);

        // R8: unicast hit and blocked unicast
        look(MAC_A, 3'b100, 5, "R8 unicast port 2");
        put(5, uc(MAC_B, 1, 1'b1));
        look(MAC_B, 3'b000, 7, "R8 blocked");

        // R9: multicast mask
        put(7, mc(MAC_M, 3'b011));
        look(MAC_M, 3'b011, 9, "R9 multicast");

        // R7: lowest index wins
        put(1, uc(MAC_A, 0, 1'b0));
        look(MAC_A, 3'b001, 3, "R7 priority");

        // R13: VLAN-only type never matches
        ea = '0; ea[61:60] = 2'd2; ea[47:0] = MAC_C;
        put(0, ea);
        look(MAC_C, 3'b111, N + 1, "R13 type 2 ignored");

        // R11: port 1 learning is removed from results
        wr(4'd9, 32'd2);
        look(MAC_M, 3'b001, 9, "R11 multicast gated");
        look(MAC_X, 3'b101, N + 1, "R11 miss gated");

        // R6: bypass
        wr(4'd0, 32'h8000_0010);
        look(MAC_A, 3'b101, 1, "R6 bypass");
        wr(4'd0, 32'h8000_0000);

        // R12: request during a scan is ignored
        lk_mac = MAC_X; lk_req = 1'b1;
        @(negedge clk);
        lk_req = 1'b0;
        n = 0;
        for (int c = 0; c < 30; c++) begin
            if (c == 3) begin lk_mac = MAC_A; lk_req = 1'b1; end
            if (c == 4) lk_req = 1'b0;
            if (lk_valid) begin
                n++;
                chk(lk_mask == 3'b101, "R12 only first result", 32'(lk_mask), 32'b101);
            end
            @(negedge clk);
        end
        chk(n == 1, "R12 single result", n, 1);

        // R4: wipe
        wr(4'd0, 32'hC000_0000);
        n = 0;
        rd(4'd0, d);
        while (d[30] && n < 40) begin
            n++;
            @(negedge clk);
            rd(4'd0, d);
        end
        chk(n == N, "R4 wipe duration", n, N);
        ea = uc(MAC_A, 2, 1'b0);
        wr(4'd1, 32'd3);
        rd(4'd3, d);
        chk(d == (ea[63:32] & ~32'h3000_0000), "R4 only type cleared", d, ea[63:32] & ~32'h3000_0000);
        rd(4'd4, d);
        chk(d == ea[31:0], "R4 address kept", d, ea[31:0]);
        look(MAC_A, 3'b101, N + 1, "R4 wiped table misses");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule